// File: doc/BRIEF.md
# Machine-Cycle Clock Divider with Switchback

This block derives the machine-cycle timing of an 8-bit controller core from the oscillator clock. It produces a single-clock enable strobe once per machine cycle, and every other part of the core advances only on that strobe. Software picks one of three cycle lengths through a small configuration write port: a full-speed ratio and two low-power ratios that stretch each machine cycle. The current mode can be read back.

Software can also arm a switchback. While it is armed, either of two wake events clears the mode field to full speed without software help. The first is an external interrupt request. The second is the start of a serial character, seen as a falling edge on the receive line, which idles high. A new ratio, whether written by software or forced by a wake event, applies only from the next machine-cycle boundary. The cycle in progress always runs to its full length.

Top module: `mcyc_clkdiv`

## Requirements
- R1: After reset the mode reads 2'b00, the strobe is low, and the first strobe appears 4 clocks after reset is released.
- R2: The strobe `mc_stb` is high for exactly one clock per machine cycle.
- R3: Mode 2'b00 gives a 4-clock machine cycle. The reserved code 2'b01 also gives 4 clocks.
- R4: Mode 2'b10 gives a 64-clock machine cycle and mode 2'b11 gives a 256-clock machine cycle.
- R5: A write (`cfg_we` high for one clock) stores `cfg_mode` and `cfg_swb`. The new mode is visible on `mode_rd` in the clock after the write.
- R6: A ratio change takes effect only at a machine-cycle boundary. The cycle running when the mode changes completes at its old length, and the following cycle uses the new length.
- R7: When switchback is armed (`cfg_swb` written as 1), a high `irq_req` clears the mode to 2'b00 on the next clock. Once the current cycle ends, machine cycles last 4 clocks.
- R8: When switchback is armed, a falling edge on `rxd` clears the mode to 2'b00 on the third clock after the edge, because the line first passes a two-flop synchronizer. Once the current cycle ends, machine cycles last 4 clocks.
- R9: When switchback is not armed, `irq_req` and falls of `rxd` leave the mode and the cycle length unchanged.
- R10: A receive line that is held low, or that rises, causes no switchback. Only a high-to-low transition counts.
- R11: If a wake event and a configuration write occur in the same clock, the wake event wins and the mode becomes 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode to write: 00 = /4, 01 = /4 (reserved), 10 = /64, 11 = /256 |
| cfg_swb | input | 1 | Switchback arm bit to write |
| irq_req | input | 1 | External interrupt request (synchronous to clk) |
| rxd | input | 1 | Serial receive line, asynchronous, idle high |
| mc_stb | output | 1 | One-clock machine-cycle strobe |
| mode_rd | output | 2 | Current mode field, for software read-back |

## Verification
The bench measures whole strobe periods across every mode change. This catches a design that cuts the running cycle short or applies the new ratio one cycle late. It times the receive-line wake to the exact clock, which exposes a synchronizer that is too short or too long. It also holds the line low across arming, so a design that detects the level instead of the edge would drop to full speed with no start bit. A write that coincides with an interrupt shows whether the hardware wake or the software value wins. Wake events are also applied while switchback is disarmed, to catch a design that acts on them anyway.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    typedef enum logic [1:0] {
        MODE_FULL = 2'b00,
        MODE_RSVD = 2'b01,
        MODE_MID  = 2'b10,
        MODE_SLOW = 2'b11
    } mcd_mode_e;

    typedef struct packed {
        mcd_mode_e mode;
        logic      swb_en;
    } mcd_cfg_t;

endpackage

// File: rtl/mcd_rx_edge.sv
module mcd_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic rx_fall
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [LAST:0] sync;
        logic          prev;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = LAST; i > 0; i--) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.sync[0] = rxd;
        st_d.prev    = st_q.sync[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sync: '1, prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_fall = st_q.prev & ~st_q.sync[LAST];

endmodule

// File: rtl/mcd_mode_reg.sv
module mcd_mode_reg
    import mcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [1:0] wr_mode,
    input  logic      wr_swb,
    input  logic      irq_req,
    input  logic      rx_fall,
    output mcd_mode_e mode,
    output logic      swb_en
);
    mcd_cfg_t cfg_d, cfg_q;
    logic     wake;

    always_comb begin
        cfg_d = cfg_q;
        wake  = cfg_q.swb_en & (irq_req | rx_fall);
        if (wr_en) begin
            cfg_d.mode   = mcd_mode_e'(wr_mode);
            cfg_d.swb_en = wr_swb;
        end
        if (wake) begin
            cfg_d.mode = MODE_FULL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_FULL, swb_en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode   = cfg_q.mode;
    assign swb_en = cfg_q.swb_en;

endmodule

// File: rtl/mcd_cycle_gen.sv
module mcd_cycle_gen
    import mcd_pkg::*;
#(
    parameter int FULL_DIV = 4,
    parameter int MID_DIV  = 64,
    parameter int SLOW_DIV = 256
) (
    input  logic      clk,
    input  logic      rst_n,
    input  mcd_mode_e mode,
    output logic      stb
);
    localparam int CNT_W = $clog2(SLOW_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic             stb;
    } cyc_state_t;

    cyc_state_t st_d, st_q;

    function automatic logic [CNT_W-1:0] last_of(mcd_mode_e m);
        case (m)
            MODE_MID:  return CNT_W'(MID_DIV - 1);
            MODE_SLOW: return CNT_W'(SLOW_DIV - 1);
            default:   return CNT_W'(FULL_DIV - 1);
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == st_q.last) begin
            st_d.cnt  = '0;
            st_d.stb  = 1'b1;
            st_d.last = last_of(mode);
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.stb  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, last: CNT_W'(FULL_DIV - 1), stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stb = st_q.stb;

endmodule

// File: rtl/mcyc_clkdiv.sv
module mcyc_clkdiv
    import mcd_pkg::*;
#(
    parameter int FULL_DIV    = 4,
    parameter int MID_DIV     = 64,
    parameter int SLOW_DIV    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_swb,
    input  logic       irq_req,
    input  logic       rxd,
    output logic       mc_stb,
    output logic [1:0] mode_rd
);
    logic      rx_fall;
    logic      swb_en;
    mcd_mode_e cur_mode;

    mcd_rx_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_rx_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .rx_fall (rx_fall)
    );

    mcd_mode_reg i_mode_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_mode (cfg_mode),
        .wr_swb  (cfg_swb),
        .irq_req (irq_req),
        .rx_fall (rx_fall),
        .mode    (cur_mode),
        .swb_en  (swb_en)
    );

    mcd_cycle_gen #(
        .FULL_DIV (FULL_DIV),
        .MID_DIV  (MID_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) i_cycle_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (cur_mode),
        .stb   (mc_stb)
    );

    assign mode_rd = cur_mode;

endmodule

// File: rtl/mcyc_clkdiv_chk.sv
module mcyc_clkdiv_chk #(
    parameter int SLOW_DIV = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [1:0] cfg_mode,
    input logic       irq_req,
    input logic       rx_fall,
    input logic       swb_en,
    input logic [1:0] mode,
    input logic       mc_stb
);
    localparam int GW = $clog2(SLOW_DIV) + 2;

    logic [GW-1:0] gap_q;
    logic          wake;

    assign wake = swb_en & (irq_req | rx_fall);

    always_ff @(posedge clk) begin
        if (!rst_n || mc_stb) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R2: strobe lasts a single clock
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb |=> !mc_stb);

    // R4: no machine cycle exceeds the longest ratio
    a_r4_max_gap: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GW'(SLOW_DIV));

    // R5: a write without a wake event lands in the mode field
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !wake) |=> (mode == $past(cfg_mode)));

    // R7 / R11: an armed interrupt forces full speed
    a_r7_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (swb_en && irq_req) |=> (mode == 2'b00));

    // R9: without write or armed wake the mode holds
    a_r9_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !wake) |=> $stable(mode));

endmodule

bind mcyc_clkdiv mcyc_clkdiv_chk #(
    .SLOW_DIV(SLOW_DIV)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .irq_req  (irq_req),
    .rx_fall  (rx_fall),
    .swb_en   (swb_en),
    .mode     (mode_rd),
    .mc_stb   (mc_stb)
);

// File: tb/test_mcyc_clkdiv.sv
`timescale 1ns/1ps
module test_mcyc_clkdiv;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_mode;
    logic       cfg_swb;
    logic       irq_req;
    logic       rxd;
    logic       mc_stb;
    logic [1:0] mode_rd;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mcyc_clkdiv i_mcyc_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_swb  (cfg_swb),
        .irq_req  (irq_req),
        .rxd      (rxd),
        .mc_stb   (mc_stb),
        .mode_rd  (mode_rd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // from a strobe cycle, count clocks to the next strobe
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check("R2 strobe one clock", mc_stb, 0);
        end while (!mc_stb);
    endtask

    task automatic wait_stb();
        while (!mc_stb) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic s);
        cfg_we = 1'b1; cfg_mode = m; cfg_swb = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called in a strobe cycle: write, then check remainder and next period
    task automatic set_and_measure(input logic [1:0] m, input logic s,
                                   input int old_len, input int new_len);
        int rem;
        write_cfg(m, s);
        check("R5 mode readback", mode_rd, m);
        rem = 1;
        while (!mc_stb) begin
            @(negedge clk);
            rem++;
        end
        check("R6 running cycle keeps old length", rem, old_len);
        gap(rem);
        check((m[1] ? "R4 slow period" : "R3 full period"), rem, new_len);
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 2'b00; cfg_swb = 1'b0;
        irq_req = 1'b0; rxd = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset mode", mode_rd, 0);
        check("R1 reset strobe low", mc_stb, 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!mc_stb && n < 20);
        check("R1 first strobe delay", n, 4);
    endtask

    task automatic t_ratios();
        int n;
        gap(n);
        check("R3 div4 period", n, 4);
        set_and_measure(2'b01, 1'b0, 4, 4);
        set_and_measure(2'b10, 1'b0, 4, 64);
        set_and_measure(2'b11, 1'b0, 64, 256);
        set_and_measure(2'b00, 1'b0, 256, 4);
    endtask

    task automatic t_irq_wake();
        int rem, n;
        set_and_measure(2'b11, 1'b1, 4, 256);
        repeat (10) @(negedge clk);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        check("R7 irq clears mode", mode_rd, 0);
        rem = 11;
        while (!mc_stb) begin @(negedge clk); rem++; end
        check("R6 slow cycle completes after irq", rem, 256);
        gap(n);
        check("R7 full speed after irq", n, 4);
    endtask

    task automatic t_rx_wake();
        int n;
        set_and_measure(2'b10, 1'b1, 4, 64);
        repeat (5) @(negedge clk);
        rxd = 1'b0;
        @(negedge clk);
        check("R8 mode after 1 clock", mode_rd, 2);
        @(negedge clk);
        check("R8 mode after 2 clocks", mode_rd, 2);
        @(negedge clk);
        check("R8 mode after 3 clocks", mode_rd, 0);
        rxd = 1'b1;
        wait_stb();
        gap(n);
        check("R8 full speed after start bit", n, 4);
    endtask

    task automatic t_disarmed();
        int n;
        set_and_measure(2'b10, 1'b0, 4, 64);
        repeat (3) @(negedge clk);
        irq_req = 1'b1; rxd = 1'b0;
        @(negedge clk);
        irq_req = 1'b0;
        repeat (6) @(negedge clk);
        check("R9 mode kept while disarmed", mode_rd, 2);
        rxd = 1'b1;
        wait_stb();
        gap(n);
        check("R9 period kept while disarmed", n, 64);
    endtask

    task automatic t_level();
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        write_cfg(2'b11, 1'b1);
        repeat (8) @(negedge clk);
        check("R10 low level no wake", mode_rd, 3);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 rising edge no wake", mode_rd, 3);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 falling edge wakes", mode_rd, 0);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_priority();
        write_cfg(2'b10, 1'b1);
        repeat (2) @(negedge clk);
        irq_req = 1'b1;
        write_cfg(2'b11, 1'b1);
        irq_req = 1'b0;
        check("R11 wake beats write", mode_rd, 0);
        wait_stb();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ratios();
                t_irq_wake();
                t_rx_wake();
                t_disarmed();
                t_level();
                t_priority();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule